// File: doc/BRIEF.md
# Quadrant Bank Controller with Address-Line Inversion

This block sits between an address translator and external memory devices. Each access arrives as a 20-bit physical address with a read or write request. The two top address bits pick one of four 256 KB quadrants. Each quadrant has its own 8-bit bank control register. That register chooses the chip select and the enable strobe set for the access. It also sets the number of wait states, whether writes are blocked, and whether the two top address lines are flipped before they reach the device.

Flipping the top lines lets one quadrant reach any 256 KB bank of a 1 MB device. The value needed is the device bank number XOR the quadrant number. For example, the quadrant at 0x80000 reaches device offset 0x55000 when both flip bits are set.

The register for the quadrant being hit controls the whole access. The chip select and enable are held low for one cycle plus the wait-state count. A one-cycle ready pulse then ends the access. Software loads the registers through a simple write port.

Top module: `qbank_ctrl`

## Requirements
- R1: Bits [19:18] of `req_addr` pick the quadrant (0 to 3). The bank register of that quadrant, as held at the accepting clock edge, supplies every setting for the access.
- R2: `dev_addr[17:0]` equals `req_addr[17:0]`. `dev_addr[19]` is `req_addr[19]` XOR register bit 5, and `dev_addr[18]` is `req_addr[18]` XOR register bit 4. The value is captured at acceptance and held until the next accepted access.
- R3: The bank register fields are:
  - [1:0] chip select number 0 to 2. The value 3 drives no chip select.
  - [2] strobe set 0 or 1.
  - [3] write protect.
  - [5:4] address flip bits.
  - [7:6] wait states 0 to 3.
- R4: A read is accepted on a clock edge where the block is idle and `req_rd` is high. For the next 1+wait cycles, the selected `cs_n` bit and `oe_n[set]` are low. In the following cycle, `ready` is high for exactly one cycle.
- R5: A write follows the same timing as a read, but drives `we_n[set]` low instead of `oe_n`.
- R6: A write to a quadrant with write protect set drives no `we_n` low. It still asserts the chip select and still finishes with `ready`. `prot_err` is high in that `ready` cycle only.
- R7: At most one `cs_n` bit and at most one enable (`oe_n` or `we_n`) are low at any time. All strobes are high when idle and during the `ready` cycle.
- R8: Reset (`rst_n` low, synchronous) clears all bank registers to 0x00 and puts the block in idle with all strobes high and `ready` low.
- R9: Requests while an access is in progress, including its `ready` cycle, are ignored. When `req_rd` and `req_wr` are both high, the access is a read.
- R10: A register write (`cfg_we`) on the same edge that accepts a request does not affect that request. It applies only to later accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Bank register write strobe |
| cfg_sel | input | 2 | Bank register index (quadrant) |
| cfg_wdata | input | 8 | Bank register write data |
| req_addr | input | 20 | Physical address of request |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| dev_addr | output | 20 | Device address after line flipping |
| cs_n | output | 3 | Active-low chip selects |
| oe_n | output | 2 | Active-low output enables, one per strobe set |
| we_n | output | 2 | Active-low write enables, one per strobe set |
| ready | output | 1 | One-cycle access completion |
| prot_err | output | 1 | Write blocked by protection, with ready |

## Verification
The bench runs accesses with all four flip-bit patterns in different quadrants. This shows that the XOR is applied after the quadrant is chosen, and that each of the two lines is flipped separately.

Wait counts from 0 to 3, both strobe sets, and every chip select code (including the empty code 3) separate off-by-one timing faults from routing faults. Protected writes set apart the blocked enable from the still-active chip select and the error pulse.

Requests during busy cycles, simultaneous read and write, and a register write on the accepting edge set apart the acceptance rules. A long random run is then compared every cycle against a behavioural model.

// File: rtl/qbank_pkg.sv
// Shared field layout of the per-quadrant bank control register.
// Assumes an 8-bit register; field positions are fixed by the layout below.
package qbank_pkg;
    localparam int QUAD_W   = 2;
    localparam int NUM_QUAD = 1 << QUAD_W;
    localparam int CFG_W    = 8;
    localparam int WAIT_W   = 2;
    localparam int CSSEL_W  = 2;

    typedef struct packed {
        logic [WAIT_W-1:0]  wait_cnt;  // [7:6]
        logic [QUAD_W-1:0]  inv;       // [5:4]
        logic               wprot;     // [3]
        logic               set_sel;   // [2]
        logic [CSSEL_W-1:0] cs_sel;    // [1:0]
    } bank_cfg_t;
endpackage

// File: rtl/qbank_regfile.sv
// Holds one control register per quadrant and presents the register of the
// quadrant addressed by rd_sel. Assumes writes take effect on the next edge.
module qbank_regfile
    import qbank_pkg::*;
#(
    parameter int NQ = NUM_QUAD
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [QUAD_W-1:0] cfg_sel,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [QUAD_W-1:0] rd_sel,
    output bank_cfg_t         rd_cfg
);
    logic [CFG_W-1:0] regs [NQ];

    for (genvar g = 0; g < NQ; g++) begin : g_reg
        // Load or clear the register of quadrant g.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (cfg_we && cfg_sel == QUAD_W'(g))
                regs[g] <= cfg_wdata;
        end
    end

    // Present the register of the addressed quadrant.
    assign rd_cfg = bank_cfg_t'(regs[rd_sel]);
endmodule

// File: rtl/qbank_addr_xform.sv
// Flips the top quadrant-select address lines by the quadrant's flip bits.
// Assumes the quadrant has already been chosen from the untransformed address.
module qbank_addr_xform
    import qbank_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [QUAD_W-1:0] inv,
    output logic [ADDR_W-1:0] addr_out
);
    localparam int LOW_W = ADDR_W - QUAD_W;

    // XOR the top lines, pass the in-quadrant offset through.
    always_comb begin
        addr_out = {addr_in[ADDR_W-1 -: QUAD_W] ^ inv, addr_in[LOW_W-1:0]};
    end
endmodule

// File: rtl/qbank_seq.sv
// Access sequencer: idle, strobe phase of 1+wait cycles, then one done cycle.
// Assumes start is only meaningful while idle is high.
module qbank_seq
    import qbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WAIT_W-1:0] wait_cnt,
    output logic              idle,
    output logic              active,
    output logic              done
);
    typedef enum logic [1:0] {S_IDLE, S_ACT, S_DONE} seq_state_t;
    seq_state_t         state;
    logic [WAIT_W-1:0]  remain;

    // Advance the access phase and count down the wait states.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            remain <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    state  <= S_ACT;
                    remain <= wait_cnt;
                end
                S_ACT: if (remain == '0) state <= S_DONE;
                       else              remain <= remain - 1'b1;
                default: state <= S_IDLE;
            endcase
        end
    end

    // Decode phase flags.
    assign idle   = (state == S_IDLE);
    assign active = (state == S_ACT);
    assign done   = (state == S_DONE);
endmodule

// File: rtl/qbank_strobe.sv
// Drives active-low chip select and enable lines from the latched routing.
// Assumes cs_sel values at or above NUM_CS select nothing.
module qbank_strobe
    import qbank_pkg::*;
#(
    parameter int NUM_CS  = 3,
    parameter int NUM_SET = 2
) (
    input  logic               active,
    input  logic               is_wr,
    input  logic               wprot,
    input  logic [CSSEL_W-1:0] cs_sel,
    input  logic               set_sel,
    output logic [NUM_CS-1:0]  cs_n,
    output logic [NUM_SET-1:0] oe_n,
    output logic [NUM_SET-1:0] we_n
);
    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        // One chip select per decoded index.
        assign cs_n[i] = !(active && cs_sel == CSSEL_W'(i));
    end

    for (genvar j = 0; j < NUM_SET; j++) begin : g_set
        // Read and write enables of strobe set j.
        assign oe_n[j] = !(active && !is_wr && set_sel == 1'(j));
        assign we_n[j] = !(active && is_wr && !wprot && set_sel == 1'(j));
    end
endmodule

// File: rtl/qbank_ctrl.sv
// Quadrant bank controller top. Accepts a request while idle, latches the
// routing of the addressed quadrant and the flipped device address, and runs
// one strobe sequence. Assumes the requester waits for ready before relying
// on a new request being taken.
module qbank_ctrl
    import qbank_pkg::*;
#(
    parameter int ADDR_W  = 20,
    parameter int NUM_CS  = 3,
    parameter int NUM_SET = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [QUAD_W-1:0]  cfg_sel,
    input  logic [CFG_W-1:0]   cfg_wdata,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic               req_rd,
    input  logic               req_wr,
    output logic [ADDR_W-1:0]  dev_addr,
    output logic [NUM_CS-1:0]  cs_n,
    output logic [NUM_SET-1:0] oe_n,
    output logic [NUM_SET-1:0] we_n,
    output logic               ready,
    output logic               prot_err
);
    bank_cfg_t          sel_cfg;
    logic [ADDR_W-1:0]  xf_addr;
    logic [ADDR_W-1:0]  dev_q;
    logic               idle, active, done, start;
    logic               cur_wr, cur_wp, cur_set;
    logic [CSSEL_W-1:0] cur_cs;

    assign start = idle && (req_rd || req_wr);

    qbank_regfile #(.NQ(NUM_QUAD)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .rd_sel    (req_addr[ADDR_W-1 -: QUAD_W]),
        .rd_cfg    (sel_cfg)
    );

    qbank_addr_xform #(.ADDR_W(ADDR_W)) u_xform (
        .addr_in  (req_addr),
        .inv      (sel_cfg.inv),
        .addr_out (xf_addr)
    );

    // Capture routing, direction and device address when a request is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dev_q   <= '0;
            cur_wr  <= 1'b0;
            cur_wp  <= 1'b0;
            cur_set <= 1'b0;
            cur_cs  <= '0;
        end else if (start) begin
            dev_q   <= xf_addr;
            cur_wr  <= !req_rd;
            cur_wp  <= sel_cfg.wprot;
            cur_set <= sel_cfg.set_sel;
            cur_cs  <= sel_cfg.cs_sel;
        end
    end

    qbank_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .wait_cnt (sel_cfg.wait_cnt),
        .idle     (idle),
        .active   (active),
        .done     (done)
    );

    qbank_strobe #(.NUM_CS(NUM_CS), .NUM_SET(NUM_SET)) u_strobe (
        .active  (active),
        .is_wr   (cur_wr),
        .wprot   (cur_wp),
        .cs_sel  (cur_cs),
        .set_sel (cur_set),
        .cs_n    (cs_n),
        .oe_n    (oe_n),
        .we_n    (we_n)
    );

    assign dev_addr = dev_q;
    assign ready    = done;
    assign prot_err = done && cur_wr && cur_wp;
endmodule

// File: rtl/qbank_ctrl_chk.sv
// Protocol checker for qbank_ctrl, attached by bind. Observes ports only.
module qbank_ctrl_chk #(
    parameter int ADDR_W  = 20,
    parameter int NUM_CS  = 3,
    parameter int NUM_SET = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ADDR_W-1:0]  dev_addr,
    input logic [NUM_CS-1:0]  cs_n,
    input logic [NUM_SET-1:0] oe_n,
    input logic [NUM_SET-1:0] we_n,
    input logic               ready,
    input logic               prot_err
);
    assert_one_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    assert_one_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(~oe_n) + $countones(~we_n)) <= 1);

    assert_quiet_on_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (&cs_n && &oe_n && &we_n));

    assert_ready_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |=> !ready);

    assert_prot_with_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> ready);

    assert_prot_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_err |-> $past(&we_n));

    assert_addr_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(&cs_n) && !$past(&cs_n)) |-> $stable(dev_addr));
endmodule

bind qbank_ctrl qbank_ctrl_chk #(
    .ADDR_W(ADDR_W), .NUM_CS(NUM_CS), .NUM_SET(NUM_SET)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .dev_addr (dev_addr),
    .cs_n     (cs_n),
    .oe_n     (oe_n),
    .we_n     (we_n),
    .ready    (ready),
    .prot_err (prot_err)
);

// File: tb/qbank_ctrl_tb_top.sv
module qbank_ctrl_tb_top;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        cfg_we = 0;
    logic [1:0]  cfg_sel = 0;
    logic [7:0]  cfg_wdata = 0;
    logic [19:0] req_addr = 0;
    logic        req_rd = 0, req_wr = 0;
    logic [19:0] dev_addr;
    logic [2:0]  cs_n;
    logic [1:0]  oe_n, we_n;
    logic        ready, prot_err;

    integer n_chk = 0, n_fail = 0, cyc = 0;

    always #10 clk = ~clk;  // 50 MHz

    qbank_ctrl dut_i (.*);

    // ---------------- behavioural reference model ----------------
    integer     m_state = 0, m_cnt = 0;   // 0 idle, 1 strobe, 2 ready
    logic [7:0] m_reg [4];
    logic [19:0] m_dev = 0;
    logic [7:0] m_cfg = 0;
    logic       m_wr = 0;

    always @(posedge clk) begin
        cyc = cyc + 1;
        if (!rst_n) begin
            m_state = 0; m_cnt = 0; m_dev = 0; m_cfg = 0; m_wr = 0;
            for (int k = 0; k < 4; k++) m_reg[k] = 8'h00;
        end else begin
            case (m_state)
                0: if (req_rd || req_wr) begin
                    m_cfg = m_reg[req_addr[19:18]];
                    m_dev = {req_addr[19:18] ^ m_cfg[5:4], req_addr[17:0]};
                    m_wr  = !req_rd;
                    m_cnt = m_cfg[7:6];
                    m_state = 1;
                end
                1: if (m_cnt == 0) m_state = 2; else m_cnt = m_cnt - 1;
                default: m_state = 0;
            endcase
            if (cfg_we) m_reg[cfg_sel] = cfg_wdata;
        end
    end

    function automatic logic [2:0] exp_cs();
        if (m_state == 1 && m_cfg[1:0] != 2'd3) return ~(3'b001 << m_cfg[1:0]);
        return 3'b111;
    endfunction
    function automatic logic [1:0] exp_oe();
        if (m_state == 1 && !m_wr) return ~(2'b01 << m_cfg[2]);
        return 2'b11;
    endfunction
    function automatic logic [1:0] exp_we();
        if (m_state == 1 && m_wr && !m_cfg[3]) return ~(2'b01 << m_cfg[2]);
        return 2'b11;
    endfunction

    task automatic check(input bit ok, input string req, input [31:0] act, input [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(dev_addr == m_dev, "R2 dev_addr", dev_addr, m_dev);
            check(cs_n == exp_cs(), "R1/R3/R4 cs_n", cs_n, exp_cs());
            check(oe_n == exp_oe(), "R4 oe_n", oe_n, exp_oe());
            check(we_n == exp_we(), "R5/R6 we_n", we_n, exp_we());
            check(ready == (m_state == 2), "R4 ready", ready, m_state == 2);
            check(prot_err == (m_state == 2 && m_wr && m_cfg[3]), "R6 prot_err",
                  prot_err, m_state == 2 && m_wr && m_cfg[3]);
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [19:0] s_dev;
    logic [2:0]  s_cs;
    logic [1:0]  s_oe, s_we;
    logic        s_prot;
    integer      s_len;

    task automatic cfg_write(input [1:0] sel, input [7:0] val);
        cfg_we = 1; cfg_sel = sel; cfg_wdata = val;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic access(input [19:0] a, input bit rd, input bit wr);
        req_addr = a; req_rd = rd; req_wr = wr;
        @(negedge clk);
        req_rd = 0; req_wr = 0; cfg_we = 0;
        s_dev = dev_addr; s_cs = cs_n; s_oe = oe_n; s_we = we_n; s_len = 0;
        while (!ready) begin s_len++; @(negedge clk); end
        s_prot = prot_err;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        // R8: strobes quiet, ready low while and after reset
        check(cs_n == 3'b111 && oe_n == 2'b11 && we_n == 2'b11, "R8 strobes in reset",
              {cs_n, oe_n, we_n}, 7'h7f);
        rst_n = 1;
        @(negedge clk);
        check(ready == 0 && prot_err == 0, "R8 ready after reset", {ready, prot_err}, 0);

        // R8/R1: default register -> cs0, set0, no wait, no flip
        access(20'h12345, 1, 0);
        check(s_cs == 3'b110 && s_oe == 2'b10, "R8 default routing", {s_cs, s_oe}, 5'b11010);
        check(s_len == 1, "R4 zero-wait length", s_len, 1);
        check(s_dev == 20'h12345, "R2 no flip", s_dev, 20'h12345);

        // R2: quadrant 3 with both flip bits, cs1, set1, wait 2
        cfg_write(2'd3, 8'hB5);
        access(20'hC1500, 1, 0);
        check(s_dev == 20'h01500, "R2 both bits quadrant 3", s_dev, 20'h01500);
        check(s_cs == 3'b101 && s_oe == 2'b01, "R3 cs1 set1", {s_cs, s_oe}, 5'b10101);
        check(s_len == 3, "R4 wait-2 length", s_len, 3);

        // R2/R5: offset 0x55000 via quadrant 2, cs2, set0, wait 1, write
        cfg_write(2'd2, 8'h72);
        access(20'h95000, 0, 1);
        check(s_dev == 20'h55000, "R2 bank XOR quadrant", s_dev, 20'h55000);
        check(s_we == 2'b10 && s_oe == 2'b11 && s_cs == 3'b011, "R5 write strobes",
              {s_cs, s_oe, s_we}, 7'b0111110);
        check(s_len == 2, "R5 wait-1 length", s_len, 2);

        // R2: only bit 5 in quadrant 3
        cfg_write(2'd3, 8'h20);
        access(20'hC0000, 1, 0);
        check(s_dev == 20'h40000, "R2 upper bit only", s_dev, 20'h40000);

        // R6: protected write in quadrant 1, wait 3, set1
        cfg_write(2'd1, 8'hCC);
        access(20'h4ABCD, 0, 1);
        check(s_we == 2'b11 && s_cs == 3'b110, "R6 no write enable", {s_cs, s_we}, 5'b11011);
        check(s_prot == 1, "R6 prot_err pulse", s_prot, 1);
        check(s_len == 4, "R6 completes wait-3", s_len, 4);
        access(20'h4ABCD, 1, 0);
        check(s_oe == 2'b01 && s_prot == 0, "R6 read unaffected", {s_oe, s_prot}, 3'b010);

        // R3: chip select code 3 drives nothing
        cfg_write(2'd1, 8'h03);
        access(20'h40000, 1, 0);
        check(s_cs == 3'b111 && s_oe == 2'b10, "R3 empty cs code", {s_cs, s_oe}, 5'b11110);

        // R9: both requests -> read; request during busy ignored
        cfg_write(2'd0, 8'hC0);
        req_addr = 20'h00010; req_rd = 1; req_wr = 1;
        @(negedge clk);
        check(oe_n == 2'b10 && we_n == 2'b11, "R9 read wins", {oe_n, we_n}, 4'b1011);
        req_rd = 0; req_wr = 1; req_addr = 20'h00020;  // ignored while busy
        @(negedge clk);
        req_wr = 0;
        while (!ready) @(negedge clk);
        req_wr = 1;                                    // ignored in ready cycle
        @(negedge clk);
        req_wr = 0;
        check(cs_n == 3'b111 && we_n == 2'b11, "R9 busy request ignored", {cs_n, we_n}, 5'h1f);
        check(dev_addr == 20'h00010, "R9 address not replaced", dev_addr, 20'h00010);

        // R10: register write on the accepting edge applies to later accesses
        cfg_sel = 2'd0; cfg_wdata = 8'h01; cfg_we = 1;
        access(20'h00100, 1, 0);
        check(s_cs == 3'b110, "R10 old value used", s_cs, 3'b110);
        access(20'h00100, 1, 0);
        check(s_cs == 3'b101, "R10 new value later", s_cs, 3'b101);

        // Random run compared against the model every cycle (R1..R9)
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            cfg_we = ($urandom % 4) == 0;
            cfg_sel = 2'($urandom);
            cfg_wdata = 8'($urandom);
            req_addr = 20'($urandom);
            req_rd = ($urandom % 3) == 0;
            req_wr = ($urandom % 3) == 0;
        end
        @(negedge clk);
        cfg_we = 0; req_rd = 0; req_wr = 0;
        repeat (8) @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule